// File: doc/BRIEF.md
# Two-Pipe Display Interrupt Collector

This block gathers the interrupt events of a display controller that drives two scan-out pipes and presents them to software through one 32-bit word. Each pipe reports five event kinds: frame sync, line sync, end of frame fetch, data buffer underflow and unrecoverable buffer underflow. A sixth, shared source reports that the cursor fetch has ended. Every event is a one-cycle pulse. The block latches each pulse into a sticky status bit in the low half of the word. The matching enable bit sits exactly sixteen places higher in the upper half.

Software reads the whole word at any time and writes it in one access. A write loads the enable half as given. The same write clears every status bit where it carries a 1. A single interrupt request line is high while any latched status bit has its enable bit set. The events themselves come from the pipes and are not produced here.

Top module: `dual_pipe_irq_ctrl`

## Requirements
- R1: After reset the whole 32-bit word reads 0 and `irq_o` is low.
- R2: An event pulse sets its status bit on the next clock edge. Bit positions (src index 0..4 = frame sync, line sync, fetch end, underflow, fatal underflow): frame sync pipe B=0, pipe A=2; line sync B=1, A=3; fetch end B=5, A=6; underflow B=7, A=8; fatal underflow B=9, A=10. Here pipe A is `pipe_a_evt_i` and pipe B is `pipe_b_evt_i`.
- R3: A set status bit stays set until a write carries 1 in that bit position. Writing 0 to a status bit leaves it unchanged.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends set.
- R5: Every write loads enable bits 26:16 from the write data. A 1 enables the status bit 16 places lower and a 0 disables it.
- R6: Bits 15:11 and 31:27 always read 0, whatever value is written to them.
- R7: `irq_o` is high exactly when some status bit and its enable bit are both set. Status bits latch whether or not they are enabled.
- R8: The cursor fetch-end pulse `cursor_evt_i` latches into bit 4 and behaves like any other source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_a_evt_i | input | 5 | Pipe A event pulses, index 0..4 as in R2 |
| pipe_b_evt_i | input | 5 | Pipe B event pulses, index 0..4 as in R2 |
| cursor_evt_i | input | 1 | Cursor fetch-end pulse |
| wr_en_i | input | 1 | Write strobe for the register word |
| wr_data_i | input | 32 | Write data: enables in 31:16, clear mask in 15:0 |
| rd_data_o | output | 32 | Current register word |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Each of the eleven sources is pulsed on its own, and the position that lights up confirms the interleaved map and tells a swapped pipe or swapped kind apart. Selective write-one-to-clear masks, all-zero writes and writes that coincide with a pulse on the same bit separate a correct clear from a blind overwrite and show which side wins a collision. Toggling the enables while status is pending shows that the request line follows the enable gate and that the sticky status does not. All-ones writes probe the bits that must stay zero.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
    localparam int HALF_W     = 16;
    localparam int WORD_W     = 2 * HALF_W;
    localparam int SRC_N      = 5;
    localparam int PIPE_N     = 2;
    localparam int CURSOR_POS = 4;
    localparam int USED_N     = PIPE_N * SRC_N + 1;
    localparam logic [HALF_W-1:0] USED_MASK = HALF_W'((1 << USED_N) - 1);

    // pipe 0 = A, pipe 1 = B; src: 0 frame sync, 1 line sync, 2 fetch end,
    // 3 underflow, 4 fatal underflow
    function automatic int src_pos(input int pipe, input int src);
        int base;
        case (src)
            0:       base = 0;
            1:       base = 1;
            2:       base = 5;
            3:       base = 7;
            default: base = 9;
        endcase
        if (src < 2) return (pipe == 0) ? base + 2 : base;
        return (pipe == 0) ? base + 1 : base;
    endfunction

    typedef struct packed {
        logic [HALF_W-1:0] status;
        logic [HALF_W-1:0] enable;
    } irq_state_t;
endpackage

// File: rtl/dirq_event_map.sv
module dirq_event_map
    import dirq_pkg::*;
(
    input  logic [SRC_N-1:0]  pipe_a_i,
    input  logic [SRC_N-1:0]  pipe_b_i,
    input  logic              cursor_i,
    output logic [HALF_W-1:0] map_o
);
    logic [PIPE_N-1:0][SRC_N-1:0] evts;
    assign evts[0] = pipe_a_i;
    assign evts[1] = pipe_b_i;

    always_comb begin
        map_o = '0;
        for (int p = 0; p < PIPE_N; p++) begin
            for (int s = 0; s < SRC_N; s++) begin
                map_o[src_pos(p, s)] = evts[p][s];
            end
        end
        map_o[CURSOR_POS] = cursor_i;
    end
endmodule

// File: rtl/dirq_regfile.sv
module dirq_regfile
    import dirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] set_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [HALF_W-1:0] status_o,
    output logic [HALF_W-1:0] enable_o
);
    irq_state_t st_d, st_q;
    logic [HALF_W-1:0] clr_d;

    always_comb begin
        st_d  = st_q;
        clr_d = wr_en_i ? wr_data_i[HALF_W-1:0] : '0;
        st_d.status = ((st_q.status & ~clr_d) | set_i) & USED_MASK;
        if (wr_en_i) begin
            st_d.enable = wr_data_i[WORD_W-1:HALF_W] & USED_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign enable_o = st_q.enable;

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & USED_MASK)) |=>
        ((status_o & $past(set_i & USED_MASK)) == $past(set_i & USED_MASK)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ((status_o & $past(status_o)) == $past(status_o)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ((status_o & $past(wr_data_i[HALF_W-1:0] & ~set_i)) == '0));

    p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && |(wr_data_i[HALF_W-1:0] & set_i & USED_MASK)) |=>
        ((status_o & $past(wr_data_i[HALF_W-1:0] & set_i & USED_MASK))
            == $past(wr_data_i[HALF_W-1:0] & set_i & USED_MASK)));

    p_enable_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (enable_o == ($past(wr_data_i[WORD_W-1:HALF_W]) & USED_MASK)));

    p_enable_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(enable_o));
endmodule

// File: rtl/dual_pipe_irq_ctrl.sv
module dual_pipe_irq_ctrl
    import dirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  pipe_a_evt_i,
    input  logic [SRC_N-1:0]  pipe_b_evt_i,
    input  logic              cursor_evt_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              irq_o
);
    logic [HALF_W-1:0] set_vec;
    logic [HALF_W-1:0] status_w;
    logic [HALF_W-1:0] enable_w;

    dirq_event_map i_map (
        .pipe_a_i (pipe_a_evt_i),
        .pipe_b_i (pipe_b_evt_i),
        .cursor_i (cursor_evt_i),
        .map_o    (set_vec)
    );

    dirq_regfile i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .status_o  (status_w),
        .enable_o  (enable_w)
    );

    assign rd_data_o = {enable_w, status_w};
    assign irq_o     = |(status_w & enable_w);

    p_unused_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data_o[HALF_W-1:0] & ~USED_MASK) == '0) &&
        ((rd_data_o[WORD_W-1:HALF_W] & ~USED_MASK) == '0));

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(rd_data_o[HALF_W-1:0] & rd_data_o[WORD_W-1:HALF_W])));

    p_cursor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_evt_i |=> rd_data_o[CURSOR_POS]);
endmodule

// File: tb/test_dual_pipe_irq_ctrl.sv
module test_dual_pipe_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  pa = '0, pb = '0;
    logic        cur = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int st = 0;
    int en = 0;

    always #2 clk = ~clk;

    dual_pipe_irq_ctrl i_dual_pipe_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pipe_a_evt_i(pa), .pipe_b_evt_i(pb),
        .cursor_evt_i(cur), .wr_en_i(wr), .wr_data_i(wd),
        .rd_data_o(rd), .irq_o(irq)
    );

    function automatic int bitpos(input int pipe, input int src);
        // pipe 0 = A, 1 = B
        int t [2][5] = '{'{2, 3, 6, 8, 10}, '{0, 1, 5, 7, 9}};
        return t[pipe][src];
    endfunction

    function automatic int ev_bits(input logic [4:0] a, input logic [4:0] b, input logic c);
        int r = 0;
        for (int s = 0; s < 5; s++) begin
            if (a[s]) r |= (1 << bitpos(0, s));
            if (b[s]) r |= (1 << bitpos(1, s));
        end
        if (c) r |= 16;
        return r;
    endfunction

    task automatic compare(input string tag);
        logic [31:0] exp_word;
        logic        exp_irq;
        exp_word = {en[15:0], st[15:0]};
        exp_irq  = (st & en) != 0;
        checks++;
        if (rd !== exp_word || irq !== exp_irq) begin
            errors++;
            $display("FAIL %s: word=%h irq=%b expected word=%h irq=%b",
                     tag, rd, irq, exp_word, exp_irq);
        end
    endtask

    // drive at negedge, model updates on the edge, compare at next negedge
    task automatic step(input logic [4:0] a, input logic [4:0] b, input logic c,
                        input logic w, input logic [31:0] d, input string tag);
        int ev;
        pa = a; pb = b; cur = c; wr = w; wd = d;
        @(posedge clk);
        ev = ev_bits(a, b, c);
        st = ((st & ~(w ? int'(d[15:0]) : 0)) | ev) & 32'h7FF;
        if (w) en = int'(d[31:16]) & 32'h7FF;
        @(negedge clk);
        pa = '0; pb = '0; cur = 1'b0; wr = 1'b0; wd = '0;
        compare(tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        step('0, '0, 0, 1, 32'h07FF_0000, "R5 enable all");
        for (int s = 0; s < 5; s++) begin
            step(5'(1 << s), '0, 0, 0, '0, "R2 pipe A source");
            step('0, '0, 0, 1, 32'h07FF_FFFF, "R3 clear all");
            step('0, 5'(1 << s), 0, 0, '0, "R2 pipe B source");
            step('0, '0, 0, 1, 32'h07FF_FFFF, "R3 clear all");
        end
        step('0, '0, 1, 0, '0, "R8 cursor latch");
        step(5'h1F, 5'h1F, 0, 0, '0, "R2 all sources");
        step('0, '0, 0, 1, 32'h07FF_0000, "R3 write zero keeps");
        step('0, '0, 0, 1, 32'h07FF_0015, "R3 selective clear");
        step('0, '0, 0, 0, '0, "R3 hold");
        step(5'h01, 5'h01, 0, 1, 32'h07FF_0005, "R4 event wins");
        step('0, '0, 0, 1, 32'h0000_0000, "R7 disabled irq low");
        step(5'h04, '0, 0, 0, '0, "R7 latch while disabled");
        step('0, '0, 0, 1, 32'h0040_0000, "R7 single enable");
        step('0, '0, 0, 1, 32'h0080_0040, "R7 enable other bit");
        step('0, '0, 0, 1, 32'hFFFF_FFFF, "R6 all ones write");
        step(5'h1F, 5'h1F, 1, 0, '0, "R6 unused stay zero");
        step('0, '0, 0, 1, 32'h0010_FFEF, "R8 cursor enabled");
        step('0, '0, 0, 1, 32'h0010_0010, "R8 cursor clear");
        step('0, 5'h10, 0, 0, '0, "R7 pending disabled");
        step('0, '0, 0, 1, 32'h0200_0000, "R5 enable pending");
        rst_n = 1'b0;
        @(posedge clk);
        st = 0; en = 0;
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 second reset");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule